// File: doc/BRIEF.md
# Multiframe Counter Alignment Machine

This block follows a 256-frame multiframe using the 8-bit multiframe number that arrives once in every frame. Each frame appears as a one-cycle valid strobe carrying the received number. The block keeps a free-running expected counter and decides whether that counter is locked to the received sequence. It reports the expected number of the next frame, a one-cycle multiframe-start pulse, and an out-of-multiframe flag.

The block starts out of alignment. It locks when two back-to-back frames carry numbers that step up by exactly one, modulo 256. The counter then takes its phase from the received value. Once locked, it drops out of alignment only after five frames in a row miss the expected number. While out of alignment the counter keeps advancing on every frame, so the multiframe start keeps its last known phase.

The frame input is a valid-only stream: the block takes every strobe in the cycle it appears and never applies back-pressure. The upstream side may therefore present frames in any cycle, back to back or spaced apart. The status and counter outputs are plain registered levels.

Top module: `mframe_align`

## Requirements
- R1: During and right after reset, `oom` is 1, `exp_num` is 0 and `mf_start` is 0.
- R2: Every accepted frame advances the expected counter by one modulo 256, in both states, unless that frame causes a lock. The new value appears on `exp_num` in the cycle after the strobe.
- R3: While out of alignment, a frame whose number equals the previous frame's number plus one (mod 256) clears `oom` in the next cycle. On that frame `exp_num` becomes the received number plus one.
- R4: The increment test wraps, so a frame carrying 0 after a frame carrying 255 is a valid locking pair.
- R5: While out of alignment, a frame that does not step up by one from the previous frame leaves `oom` at 1. The first frame after reset cannot lock on its own.
- R6: While aligned, the fifth frame in a row whose number differs from the expected counter sets `oom` in the next cycle. Four such frames in a row leave `oom` at 0.
- R7: While aligned, a frame that matches the expected number restarts the mismatch run, so a later loss needs five fresh mismatches in a row.
- R8: `mf_start` is high for exactly the one cycle after a strobe whose frame number is 0. The frame number is the expected count, or the received value on a locking frame.
- R9: Apart from a locking frame, the received numbers never load the counter. In both states `exp_num` depends only on the count of frames since the last lock or reset.
- R10: With no strobe, `exp_num`, `oom` and `mf_start` (which then reads 0) do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe, one per received frame |
| frm_mfn | input | 8 | Multiframe number received with the strobe |
| exp_num | output | 8 | Expected multiframe number of the next frame |
| mf_start | output | 1 | One-cycle pulse after a frame numbered 0 |
| oom | output | 1 | High while out of multiframe alignment |

## Verification
On every cycle, the assertions check these properties:
- the counter steps by one on each non-locking strobe and holds otherwise;
- the mismatch run stays below its limit;
- each lock loads the received value plus one;
- every change of `oom` or pulse of `mf_start` follows a strobe.

Some behaviours only the bench's scenarios can show:
- that the exact pair rule decides lock, across all 256 starting values including the wrap;
- that loss happens on the fifth mismatch and not the fourth;
- that a single match resets the run.

A reference model drives the bench's comparisons on every frame.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  typedef enum logic {
    ST_OOM = 1'b0,
    ST_IM  = 1'b1
  } align_st_t;

  localparam int unsigned DEF_NUM_W = 8;
  localparam int unsigned DEF_LOSS  = 5;
endpackage

// File: rtl/mfa_counter.sv
module mfa_counter #(
  parameter int unsigned NUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [NUM_W-1:0] load_val,
  output logic [NUM_W-1:0] cur,
  output logic             start
);
  localparam logic [NUM_W-1:0] ONE = NUM_W'(1);

  logic [NUM_W-1:0] frame_no;

  // number assigned to the frame being accepted now
  always_comb begin
    frame_no = load ? load_val : cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= '0;
      start <= 1'b0;
    end else begin
      start <= step && (frame_no == '0);
      if (step) begin
        cur <= frame_no + ONE;
      end
    end
  end

  // R2: plain step advances by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cur == $past(cur) + ONE));
  // R10: no strobe, no movement
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cur));
endmodule

// File: rtl/mfa_acq.sv
module mfa_acq #(
  parameter int unsigned NUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [NUM_W-1:0] rx,
  output logic             pair_ok
);
  localparam logic [NUM_W-1:0] ONE = NUM_W'(1);

  logic [NUM_W-1:0] prev;
  logic             have_prev;

  always_comb begin
    pair_ok = have_prev && (rx == prev + ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev      <= '0;
      have_prev <= 1'b0;
    end else if (step) begin
      prev      <= rx;
      have_prev <= 1'b1;
    end
  end

  // R5: the first frame after reset has no predecessor
  a_r5_no_early_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (!have_prev && !step) |=> !have_prev);
endmodule

// File: rtl/mfa_loss.sv
module mfa_loss #(
  parameter int unsigned LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic active,
  input  logic miss,
  output logic lose
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] run;

  always_comb begin
    lose = step && active && miss && (run == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
    end else if (!active) begin
      run <= '0;
    end else if (step) begin
      if (!miss || lose) run <= '0;
      else               run <= run + ONE;
    end
  end

  // R6: the run never reaches the limit
  a_r6_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run <= LAST);
  // R7: a match restarts the run
  a_r7_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (step && active && !miss) |=> (run == '0));
endmodule

// File: rtl/mframe_align.sv
module mframe_align
  import mfa_pkg::*;
#(
  parameter int unsigned NUM_W = DEF_NUM_W,
  parameter int unsigned LOSS  = DEF_LOSS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic [NUM_W-1:0] frm_mfn,
  output logic [NUM_W-1:0] exp_num,
  output logic             mf_start,
  output logic             oom
);
  align_st_t        st;
  logic             pair_ok;
  logic             lock;
  logic             lose;
  logic             miss;
  logic [NUM_W-1:0] cur;

  always_comb begin
    lock    = frm_valid && (st == ST_OOM) && pair_ok;
    miss    = (frm_mfn != cur);
    oom     = (st == ST_OOM);
    exp_num = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OOM;
    end else if (lock) begin
      st <= ST_IM;
    end else if (lose) begin
      st <= ST_OOM;
    end
  end

  mfa_counter #(.NUM_W(NUM_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(frm_valid), .load(lock),
    .load_val(frm_mfn), .cur(cur), .start(mf_start)
  );

  mfa_acq #(.NUM_W(NUM_W)) u_acq (
    .clk(clk), .rst_n(rst_n), .step(frm_valid), .rx(frm_mfn), .pair_ok(pair_ok)
  );

  mfa_loss #(.LIMIT(LOSS)) u_loss (
    .clk(clk), .rst_n(rst_n), .step(frm_valid), .active(st == ST_IM),
    .miss(miss), .lose(lose)
  );

  // R3: a lock loads the received number plus one
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oom) |-> (exp_num == $past(frm_mfn) + NUM_W'(1)));
  // R6: a loss only follows a frame
  a_r6_loss_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oom) |-> $past(frm_valid));
  // R8: start pulse only follows a frame
  a_r8_start_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |-> $past(frm_valid));
  // R10: state holds with no frame
  a_r10_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> $stable(oom));
endmodule

// File: tb/tb_mframe_align.sv
module tb_mframe_align;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_valid = 1'b0;
  logic [7:0] frm_mfn = 8'd0;
  logic [7:0] exp_num;
  logic       mf_start;
  logic       oom;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic       m_oom;
  logic [7:0] m_exp;
  logic [7:0] m_prev;
  logic       m_hp;
  int         m_miss;
  logic       m_start;

  always #10 clk = ~clk;

  mframe_align dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_mfn(frm_mfn),
    .exp_num(exp_num), .mf_start(mf_start), .oom(oom)
  );

  task automatic chk(input string req, input int act, input int expv, input string what);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    frm_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_oom = 1'b1; m_exp = 8'd0; m_prev = 8'd0; m_hp = 1'b0; m_miss = 0; m_start = 1'b0;
  endtask

  task automatic frame(input logic [7:0] v, input string req);
    logic [7:0] fn;
    logic       lk;
    @(negedge clk);
    frm_valid = 1'b1;
    frm_mfn   = v;
    @(negedge clk);
    frm_valid = 1'b0;
    fn = m_exp;
    lk = 1'b0;
    if (m_oom && m_hp && (v == m_prev + 8'd1)) begin
      lk = 1'b1;
      fn = v;
    end else if (!m_oom) begin
      if (v != m_exp) begin
        if (m_miss == 4) begin m_oom = 1'b1; m_miss = 0; end
        else m_miss++;
      end else begin
        m_miss = 0;
      end
    end
    m_exp   = fn + 8'd1;
    m_start = (fn == 8'd0);
    m_prev  = v;
    m_hp    = 1'b1;
    if (lk) m_oom = 1'b0;
    chk(req, oom, m_oom, "oom");
    chk(req, exp_num, m_exp, "exp_num");
    chk("R8", mf_start, m_start, "mf_start");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", oom, 1, "oom");
    chk("R1", exp_num, 0, "exp_num");
    chk("R1", mf_start, 0, "mf_start");

    // R10 idle: nothing moves
    repeat (5) @(negedge clk);
    chk("R10", exp_num, 0, "exp_num idle");
    chk("R10", oom, 1, "oom idle");

    // R5/R9: non-consecutive frames keep OOM, counter free-runs
    frame(8'd10, "R5");
    frame(8'd50, "R5");
    frame(8'd7, "R9");
    frame(8'd7, "R5");
    @(negedge clk);
    chk("R10", mf_start, 0, "pulse width");

    // R3/R4: lock sweep over every starting value (255 covers the wrap)
    for (int s = 0; s < 256; s++) begin
      do_reset();
      frame(8'(s), "R5");
      frame(8'(s + 1), (s == 255) ? "R4" : "R3");
    end

    // R6: loss needs five mismatches in a row
    for (int n = 1; n <= 6; n++) begin
      do_reset();
      frame(8'd20, "R3");
      frame(8'd21, "R3");
      for (int k = 0; k < n; k++) frame(m_exp + 8'd7, "R6");
      frame(m_exp + 8'd3, "R9");
    end

    // R7: a match restarts the run
    do_reset();
    frame(8'd100, "R3");
    frame(8'd101, "R3");
    for (int k = 0; k < 4; k++) frame(8'd0, "R6");
    frame(m_exp, "R7");
    for (int k = 0; k < 4; k++) frame(8'd0, "R7");
    chk("R7", oom, 0, "still aligned");
    frame(8'd0, "R6");
    chk("R6", oom, 1, "lost after fifth");
    // relock right after loss
    frame(8'd1, "R3");

    // R8: start pulse through the wrap while aligned
    do_reset();
    frame(8'd250, "R3");
    frame(8'd251, "R3");
    for (int k = 0; k < 8; k++) frame(m_exp, "R8");

    // R2/R9: long free run out of alignment, through a counter wrap
    do_reset();
    for (int k = 0; k < 300; k++) frame(8'(k * 2), "R2");

    // R2: mixed aligned traffic with sporadic errors
    do_reset();
    frame(8'd5, "R3");
    frame(8'd6, "R3");
    for (int k = 0; k < 600; k++) frame((k % 7 == 3) ? m_exp + 8'd1 : m_exp, "R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule